// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between a synchronous host and an asynchronous static RAM of 16,384 words by 4 bits. The host offers one read or one write at a time over a request/ready handshake. The block then drives the memory strobes, the 14-bit address and the data pins through a fixed, cycle-counted sequence. For a read, it returns the sampled word with a one-cycle valid strobe.

The block times every analog interval of the memory from parameters given in picoseconds and rounds each one up to whole controller clock cycles. A write is the window in which chip select and write strobe are both low. The data is driven for the whole window and is held one cycle past its end. The block drives the data pins only after output enable has been high for a cycle, so the memory and the controller never drive the shared pins together. The physical tri-state buffer is left to the pad ring. The block provides an output value, an output enable and an input value for it.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, and after it, chip select, write strobe and output enable are high (inactive), the data drivers are off, ready is high and read-valid is low.
- R2: While ready is high and no request is presented, all three memory strobes stay high and the data drivers stay off (memory in standby).
- R3: A write holds the write strobe low for exactly WE_CYC consecutive cycles (2 with the defaults). Chip select is low for every such cycle and the address is stable across the pulse.
- R4: During every cycle of the write pulse, the data drivers are on and present the host's write word. The drivers stay on for the single cycle after the write strobe rises, and they are off in the cycle after that.
- R5: Output enable stays high for the whole write. The data drivers are never on while output enable is low. The drivers switch on only after a cycle in which output enable was already high.
- R6: A read holds chip select and output enable low, with the write strobe high, for exactly RD_CYC consecutive cycles (2 with the defaults). At the end of that window the word on the data input is captured and returned on the read-data output.
- R7: Read-valid is high for exactly one cycle per read, and it is never high for a write.
- R8: Ready goes low in the cycle after a request is accepted (request high while ready high, at a rising edge). It stays low for WE_CYC+2 cycles for a write (4 by default) and for RD_CYC cycles for a read (2 by default).
- R9: A word written at any address, including the lowest (0) and the highest (16383), is returned unchanged by a later read of that address.
- R10: A new request presented in the same cycle that ready returns high is accepted at once. No extra idle cycle is inserted between a write and a following read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 14 | Word address |
| req_wdata_i | input | 4 | Write word |
| req_ready_o | output | 1 | Ready to accept a request |
| rsp_rdata_o | output | 4 | Read word |
| rsp_valid_o | output | 1 | Read word valid, one-cycle pulse |
| mem_ce_n_o | output | 1 | Memory chip select, active low |
| mem_we_n_o | output | 1 | Memory write strobe, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_addr_o | output | 14 | Memory address |
| mem_dq_o | output | 4 | Value for the data pins |
| mem_dq_oe_o | output | 1 | Enable for the data pin drivers |
| mem_dq_i | input | 4 | Value sensed on the data pins |

## Verification
The hardest case to reach from the ports is the turnaround between a write and a read that follows it with no gap. Here the driver release and the output-enable fall come on consecutive cycles, so a one-cycle slip produces two drivers on the pins. The bench issues the read in the same cycle that ready returns after a write. A negative-edge monitor with its own memory model checks, on every cycle, that the drivers are off whenever the model would drive. The same monitor measures the length of each write-strobe run and each output-enable run.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WEND   = 3'd3,
    ST_RACC   = 3'd4
  } seq_state_e;

  // Whole clock cycles covering an interval, at least one.
  function automatic int unsigned cycles_for(input int unsigned t_ps,
                                             input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_cnt.sv
module sram_cycle_cnt #(
  parameter int unsigned CNT_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned WE_CYC = 2,
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned CNT_W  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic             cnt_zero_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ce_n_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic             drv_en_o,
  output logic             ready_o
);

  localparam logic [CNT_W-1:0] WE_LD = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);

  seq_state_e state_q, state_d;
  logic ce_n_d, we_n_d, oe_n_d, drv_d, ready_d;

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (wr_i) begin
            state_d = ST_WSETUP;
          end else begin
            state_d    = ST_RACC;
            cnt_load_o = 1'b1;
            cnt_val_o  = RD_LD;
          end
        end
      end
      ST_WSETUP: begin
        state_d    = ST_WPULSE;
        cnt_load_o = 1'b1;
        cnt_val_o  = WE_LD;
      end
      ST_WPULSE: if (cnt_zero_i) state_d = ST_WEND;
      ST_WEND:   state_d = ST_IDLE;
      ST_RACC:   if (cnt_zero_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // Strobes decoded from the next state so that every pin comes from a flop
  always_comb begin
    ce_n_d  = (state_d == ST_IDLE);
    we_n_d  = (state_d != ST_WPULSE);
    oe_n_d  = (state_d != ST_RACC);
    drv_d   = (state_d == ST_WPULSE) || (state_d == ST_WEND);
    ready_d = (state_d == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ce_n_o   <= 1'b1;
      we_n_o   <= 1'b1;
      oe_n_o   <= 1'b1;
      drv_en_o <= 1'b0;
      ready_o  <= 1'b1;
    end else begin
      state_q  <= state_d;
      ce_n_o   <= ce_n_d;
      we_n_o   <= we_n_d;
      oe_n_o   <= oe_n_d;
      drv_en_o <= drv_d;
      ready_o  <= ready_d;
    end
  end

  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign capture_o = (state_q == ST_RACC) && cnt_zero_i;

  p_drv_no_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en_o |-> oe_n_o);
  p_drv_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en_o) |-> $past(oe_n_o));
  p_we_needs_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_o |-> !ce_n_o);
  p_idle_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (ce_n_o && we_n_o && oe_n_o && !drv_en_o));
  p_read_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_o |-> (we_n_o && !ce_n_o));

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic [DATA_W-1:0] mem_din_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dout_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d, rdata_d;

  always_comb begin
    addr_d  = accept_i  ? host_addr_i  : mem_addr_o;
    wdata_d = accept_i  ? host_wdata_i : mem_dout_o;
    rdata_d = capture_i ? mem_din_i    : rdata_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr_o <= '0;
      mem_dout_o <= '0;
      rdata_o    <= '0;
      rvalid_o   <= 1'b0;
    end else begin
      mem_addr_o <= addr_d;
      mem_dout_o <= wdata_d;
      rdata_o    <= rdata_d;
      rvalid_o   <= capture_i;
    end
  end

  p_rvalid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |=> !rvalid_o);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned DATA_W    = 4,
  parameter int unsigned CLK_PS    = 10000,
  parameter int unsigned T_PWE_PS  = 12000,
  parameter int unsigned T_SD_PS   = 10000,
  parameter int unsigned T_AW_PS   = 12000,
  parameter int unsigned T_WC_PS   = 15000,
  parameter int unsigned T_AA_PS   = 15000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_valid_o,
  output logic              mem_ce_n_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  // A write occupies a setup cycle, the pulse, and an end cycle
  localparam int unsigned WC_CYC  = cycles_for(T_WC_PS, CLK_PS);
  localparam int unsigned WC_PULS = (WC_CYC > 3) ? WC_CYC - 2 : 1;
  localparam int unsigned WE_CYC  = max2(max2(cycles_for(T_PWE_PS, CLK_PS),
                                              cycles_for(T_SD_PS, CLK_PS)),
                                         max2(cycles_for(T_AW_PS, CLK_PS), WC_PULS));
  localparam int unsigned RD_CYC  = cycles_for(T_AA_PS, CLK_PS);
  localparam int unsigned CNT_MAX = max2(WE_CYC, RD_CYC);
  localparam int unsigned CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

  logic             cnt_load, cnt_zero, accept, capture;
  logic [CNT_W-1:0] cnt_val;

  sram_cycle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .zero_o     (cnt_zero)
  );

  sram_seq_fsm #(
    .WE_CYC (WE_CYC),
    .RD_CYC (RD_CYC),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .wr_i       (req_write_i),
    .cnt_zero_i (cnt_zero),
    .cnt_load_o (cnt_load),
    .cnt_val_o  (cnt_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .ce_n_o     (mem_ce_n_o),
    .we_n_o     (mem_we_n_o),
    .oe_n_o     (mem_oe_n_o),
    .drv_en_o   (mem_dq_oe_o),
    .ready_o    (req_ready_o)
  );

  sram_data_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_i     (accept),
    .capture_i    (capture),
    .host_addr_i  (req_addr_i),
    .host_wdata_i (req_wdata_i),
    .mem_din_i    (mem_dq_i),
    .mem_addr_o   (mem_addr_o),
    .mem_dout_o   (mem_dq_o),
    .rdata_o      (rsp_rdata_o),
    .rvalid_o     (rsp_valid_o)
  );

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n_o && $past(!mem_we_n_o)) |-> $stable(mem_addr_o));
  p_hold_after_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n_o) |-> mem_dq_oe_o);
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe_o) |-> $past(mem_we_n_o));
  p_no_valid_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> mem_we_n_o);

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WE_EXP     = 2;
  localparam int RD_EXP     = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_wr;
  logic [13:0] req_addr;
  logic [3:0]  req_wdata;
  logic        ready, rvalid;
  logic [3:0]  rdata;
  logic        ce_n, we_n, oe_n, dq_oe;
  logic [13:0] maddr;
  logic [3:0]  dq_o;
  logic [3:0]  dq_i;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [3:0] mem    [logic [13:0]];
  logic [3:0] shadow [logic [13:0]];
  logic [3:0] exp_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_async_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .req_write_i (req_wr),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .req_ready_o (ready),
    .rsp_rdata_o (rdata),
    .rsp_valid_o (rvalid),
    .mem_ce_n_o  (ce_n),
    .mem_we_n_o  (we_n),
    .mem_oe_n_o  (oe_n),
    .mem_addr_o  (maddr),
    .mem_dq_o    (dq_o),
    .mem_dq_oe_o (dq_oe),
    .mem_dq_i    (dq_i)
  );

  // Memory model: drives the pins when selected for reading
  always_comb begin
    dq_i = 4'h0;
    if (!ce_n && !oe_n && we_n && mem.exists(maddr)) dq_i = mem[maddr];
  end

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req_tag, act, exp, $time);
    end
  endtask

  // Cycle monitor on the memory side
  bit          mon_en = 1'b0;
  logic        p_we = 1'b1, p_oe = 1'b1, p_drv = 1'b0;
  logic [13:0] p_addr;
  logic [3:0]  p_dq;
  int          we_run = 0, oe_run = 0;
  bit          exp_rel = 1'b0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (dq_oe && !oe_n) check(1'b0, "R5 drivers on while output enable low", 1, 0);
      if (!we_n) begin
        check(!oe_n == 1'b0, "R5 oe high during write", oe_n, 1);
        check(!ce_n, "R3 ce low during pulse", ce_n, 0);
        check(dq_oe && dq_o == exp_wdata, "R4 data driven in pulse", dq_o, exp_wdata);
        if (!p_we) check(maddr == p_addr, "R3 address stable", maddr, p_addr);
      end
      if (dq_oe && !p_drv) check(p_oe, "R5 drivers after oe high", p_oe, 1);
      if (exp_rel) begin
        check(!dq_oe, "R4 drivers released", dq_oe, 0);
        exp_rel = 1'b0;
      end
      if (!p_we && we_n) begin
        check(dq_oe && dq_o == exp_wdata, "R4 hold after write", dq_o, exp_wdata);
        check(we_run == WE_EXP, "R3 pulse length", we_run, WE_EXP);
        mem[p_addr] = p_dq;
        exp_rel = 1'b1;
      end
      if (!oe_n) oe_run++;
      else if (oe_run != 0) begin
        check(oe_run == RD_EXP, "R6 read window length", oe_run, RD_EXP);
        oe_run = 0;
      end
      we_run = !we_n ? we_run + 1 : 0;
    end
    p_we = we_n; p_oe = oe_n; p_drv = dq_oe; p_addr = maddr; p_dq = dq_o;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic issue(input bit wr, input logic [13:0] a, input logic [3:0] d);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    if (wr) exp_wdata = d;
    while (!ready) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic do_write(input logic [13:0] a, input logic [3:0] d);
    int busy = 0;
    issue(1'b1, a, d);
    shadow[a] = d;
    while (!ready) begin
      busy++;
      if (rvalid) check(1'b0, "R7 valid during write", 1, 0);
      @(negedge clk);
    end
    check(busy == WE_EXP + 2, "R8 write busy cycles", busy, WE_EXP + 2);
    check(!rvalid, "R7 no valid after write", rvalid, 0);
  endtask

  task automatic do_read(input logic [13:0] a, input string tag);
    int busy = 0;
    issue(1'b0, a, 4'h0);
    while (!ready) begin
      busy++;
      @(negedge clk);
    end
    check(busy == RD_EXP, "R8 read busy cycles", busy, RD_EXP);
    check(rvalid, "R7 valid at completion", rvalid, 1);
    check(rdata == shadow[a], tag, rdata, shadow[a]);
    @(negedge clk);
    check(!rvalid, "R7 valid single cycle", rvalid, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
    exp_wdata = '0;
    repeat (3) @(negedge clk);
    check(ce_n && we_n && oe_n, "R1 strobes high in reset", {ce_n, we_n, oe_n}, 3'b111);
    check(!dq_oe && ready && !rvalid, "R1 drivers/ready/valid in reset",
          {dq_oe, ready, rvalid}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;
    check(ce_n && we_n && oe_n && !dq_oe && ready, "R1 state after reset",
          {ce_n, we_n, oe_n, dq_oe, ready}, 5'b11101);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(ce_n && we_n && oe_n && !dq_oe, "R2 standby when idle",
            {ce_n, we_n, oe_n, dq_oe}, 4'b1110);
    end
  endtask

  task automatic t_patterns;
    do_write(14'd0, 4'h5);
    do_write(14'd16383, 4'hA);
    do_write(14'h1234, 4'hF);
    do_write(14'h2AAA, 4'h0);
    do_read(14'd0, "R9 lowest address");
    do_read(14'd16383, "R9 highest address");
    do_read(14'h1234, "R6 read data all ones");
    do_read(14'h2AAA, "R6 read data zero");
  endtask

  task automatic t_overwrite;
    do_write(14'h0F0F, 4'h3);
    do_write(14'h0F0F, 4'hC);
    do_read(14'h0F0F, "R9 overwrite returns latest");
  endtask

  task automatic t_back_to_back;
    int gap = 0;
    do_write(14'h0777, 4'h9);
    // do_write returns at the negedge where ready came back; issue at once
    req = 1'b1; req_wr = 1'b0; req_addr = 14'h0777;
    @(negedge clk);
    req = 1'b0;
    check(!ready, "R10 read accepted with no gap", ready, 0);
    while (!ready) begin gap++; @(negedge clk); end
    check(gap == RD_EXP, "R10 read busy after write", gap, RD_EXP);
    check(rvalid && rdata == 4'h9, "R10 back-to-back read data", rdata, 4'h9);
    @(negedge clk);
  endtask

  initial begin
    t_reset;
    t_idle;
    t_patterns;
    t_overwrite;
    t_back_to_back;
    t_idle;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule